// File: doc/BRIEF.md
# Synchronous DRAM Column Burst Engine

This block is the column-access side of a compact synchronous DRAM model. On each active internal clock edge it decodes a command: no-operation, column read, column write, or load of the mode word. For reads and writes it steps a burst address counter through an aligned block of columns. Read words come out of a small internal array after a programmable CAS latency. Write words are taken on every burst beat.

A clock-enable input, registered once, gates every internal edge. A low sample freezes the following edge. Commands and write data seen on a frozen edge are discarded, the burst position does not move, and whatever read word is on the output stays there. A mode bit turns every write into a single-column access while reads keep the full burst. A data-mask input blocks array updates on write beats. On reads it blanks the output two internal edges later.

Top module: `sdr_col_engine`

## Requirements
- R1: After synchronous reset, rd_valid_out is 0 and rdata_out is 0. The mode defaults to burst length 1, sequential order, CAS latency 2 and full-burst writes.
- R2: Command cmd_in=3 loads the mode from mode_in, effective from the next internal edge. Bits [1:0] select burst length (0,1,2,3 give 1,2,4,8). Bit 2 set selects interleaved order. Bit 4 set selects CAS latency 3, clear selects 2. Bit 9 is write-single.
- R3: A READ is cmd_in=1. When sampled on internal edge E with no suspension, beat k is on rdata_out with rd_valid_out high from edge E+CL+k until the next edge.
- R4: In sequential order, beat k reads or writes the column whose low log2(BL) bits are (start + k) mod BL. The upper bits are kept.
- R5: In interleaved order, the low log2(BL) bits of beat k are the start's low bits XOR k.
- R6: A WRITE is cmd_in=2. Its wdata_in is stored at beat 0 on the command edge. With bit 9 clear, each later internal edge stores wdata_in at the next beat column until BL beats are done.
- R7: With bit 9 set, a WRITE stores exactly one column and later wdata_in is not stored. READs still run the programmed burst length.
- R8: If cke_in is sampled low at edge P, edge P+1 is suspended. The command and wdata_in present then are ignored, and rdata_out and rd_valid_out keep their values.
- R9: The burst position does not advance across a suspended edge. Beats resume in order on the next active edge.
- R10: A READ or WRITE arriving during a burst ends that burst and starts a new one at its own column.
- R11: dm_in high on a write beat prevents that beat's column from being updated.
- R12: dm_in high on internal edge P forces rd_valid_out low (and rdata_out to 0) after the second internal edge following P.
- R13: rd_valid_out is high exactly while a read word is driven. When it is low, rdata_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_in | input | 1 | Clock enable, registered to gate the next internal edge |
| cmd_in | input | 2 | 0 no-op, 1 read, 2 write, 3 load mode |
| col_in | input | COL_W | Start column for read or write |
| mode_in | input | 10 | Mode word taken by the load command |
| wdata_in | input | DW | Write data for the current beat |
| dm_in | input | 1 | Data mask: blocks a write beat, blanks a read word two edges later |
| rdata_out | output | DW | Read data, 0 when not valid |
| rd_valid_out | output | 1 | High while a read word is driven |

## Verification
The latency and masking properties assume the clock enable stays high over the edges they span. They also assume no mode load lands between a read and its data. Each property therefore fires only when its window of clock-enable samples is fully high, and the stimulus never reloads the mode while a read is still in flight. Suspension is applied as single-cycle low pulses on cke_in, placed either inside a write burst or inside a read burst whose words are already on the output. In that second case the frozen output and the discarded command can both be seen at the ports.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_LOAD  = 2'd3
  } sdr_cmd_e;

  localparam int MODE_W = 10;

  typedef struct packed {
    logic       wr_single;
    logic       cas3;
    logic       ilv;
    logic [1:0] bl_code;
  } sdr_mode_t;
endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
  import sdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              act,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output sdr_mode_t         mode_q
);
  logic unused_rsvd;
  assign unused_rsvd = ^{word[8:5], word[3]};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (act && load) begin
      mode_q <= '{wr_single: word[9], cas3: word[4], ilv: word[2], bl_code: word[1:0]};
    end
  end
endmodule

// File: rtl/sdr_burst_ctr.sv
module sdr_burst_ctr
  import sdr_pkg::*;
#(
  parameter int COL_W  = 6,
  parameter int BEAT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act,
  input  logic             start,
  input  logic             start_wr,
  input  logic             load,
  input  logic [COL_W-1:0] col_in,
  input  sdr_mode_t        mode,
  output logic             issue,
  output logic             issue_wr,
  output logic [COL_W-1:0] issue_col,
  output logic             busy_o,
  output logic [BEAT_W:0]  beat_o
);
  logic             busy_q, wr_q, ilv_q;
  logic [COL_W-1:0] base_q;
  logic [BEAT_W:0]  beat_q, len_q;

  logic [1:0]       lcode;
  logic [BEAT_W:0]  len_start, cur_len, cur_beat;
  logic [COL_W-1:0] cur_base, blk_mask, offs;
  logic             cur_ilv;

  always_comb begin
    lcode     = (start_wr && mode.wr_single) ? 2'd0 : mode.bl_code;
    len_start = (BEAT_W+1)'(1) << lcode;
    cur_base  = start ? col_in : base_q;
    cur_beat  = start ? '0 : beat_q;
    cur_len   = start ? len_start : len_q;
    cur_ilv   = start ? mode.ilv : ilv_q;
    blk_mask  = COL_W'(cur_len - (BEAT_W+1)'(1));
    offs      = cur_ilv ? (cur_base ^ COL_W'(cur_beat)) : (cur_base + COL_W'(cur_beat));
    issue_col = (cur_base & ~blk_mask) | (offs & blk_mask);
    issue     = act && (start || (busy_q && !load));
    issue_wr  = start ? start_wr : wr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      ilv_q  <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      len_q  <= '0;
    end else if (act) begin
      if (start) begin
        base_q <= col_in;
        beat_q <= (BEAT_W+1)'(1);
        len_q  <= len_start;
        wr_q   <= start_wr;
        ilv_q  <= mode.ilv;
        busy_q <= (len_start != (BEAT_W+1)'(1));
      end else if (load) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        beat_q <= beat_q + (BEAT_W+1)'(1);
        busy_q <= ((beat_q + (BEAT_W+1)'(1)) != len_q);
      end
    end
  end

  assign busy_o = busy_q;
  assign beat_o = beat_q;
endmodule

// File: rtl/sdr_col_array.sv
module sdr_col_array #(
  parameter int COL_W = 6,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [COL_W-1:0] addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << COL_W;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/sdr_read_pipe.sv
module sdr_read_pipe #(
  parameter int DW       = 8,
  parameter int MAX_CL   = 3,
  parameter int MASK_LAT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act,
  input  logic          issue_rd,
  input  logic [DW-1:0] arr_q,
  input  logic          dm,
  input  logic          cas3,
  output logic [DW-1:0] dout,
  output logic          dvalid
);
  localparam int CL_LO = 2;

  logic [MAX_CL:1]   vld;
  logic [MASK_LAT:1] msk;
  logic [DW-1:0]     dly [2:MAX_CL];
  logic              tap_v, drive;
  logic [DW-1:0]     tap_d;

  always_comb begin
    tap_v = vld[CL_LO + int'(cas3)];
    tap_d = dly[CL_LO + int'(cas3)];
    drive = tap_v && !msk[MASK_LAT];
  end

  always_ff @(posedge clk) begin
    if (act) begin
      dly[2] <= arr_q;
      for (int i = 3; i <= MAX_CL; i++) dly[i] <= dly[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= '0;
      msk    <= '0;
      dout   <= '0;
      dvalid <= 1'b0;
    end else if (act) begin
      vld    <= {vld[MAX_CL-1:1], issue_rd};
      msk    <= {msk[MASK_LAT-1:1], dm};
      dvalid <= drive;
      dout   <= drive ? tap_d : '0;
    end
  end
endmodule

// File: rtl/sdr_col_engine.sv
module sdr_col_engine
  import sdr_pkg::*;
#(
  parameter int DW       = 8,
  parameter int COL_W    = 6,
  parameter int MAX_BL   = 8,
  parameter int MAX_CL   = 3,
  parameter int MASK_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke_in,
  input  logic [1:0]        cmd_in,
  input  logic [COL_W-1:0]  col_in,
  input  logic [MODE_W-1:0] mode_in,
  input  logic [DW-1:0]     wdata_in,
  input  logic              dm_in,
  output logic [DW-1:0]     rdata_out,
  output logic              rd_valid_out
);
  localparam int BEAT_W = $clog2(MAX_BL);

  logic       act;
  sdr_cmd_e   cmd;
  logic       start, start_wr, load;
  sdr_mode_t  mode_q;
  logic       issue, issue_wr, burst_busy;
  logic [COL_W-1:0] issue_col;
  logic [BEAT_W:0]  burst_beat;
  logic [DW-1:0]    arr_q;

  always_ff @(posedge clk) begin
    if (rst) act <= 1'b1;
    else     act <= cke_in;
  end

  always_comb begin
    cmd      = sdr_cmd_e'(cmd_in);
    start    = (cmd == CMD_READ) || (cmd == CMD_WRITE);
    start_wr = (cmd == CMD_WRITE);
    load     = (cmd == CMD_LOAD);
  end

  sdr_mode_reg u_mode (
    .clk(clk), .rst(rst), .act(act), .load(load), .word(mode_in), .mode_q(mode_q)
  );

  sdr_burst_ctr #(.COL_W(COL_W), .BEAT_W(BEAT_W)) u_ctr (
    .clk(clk), .rst(rst), .act(act), .start(start), .start_wr(start_wr),
    .load(load), .col_in(col_in), .mode(mode_q), .issue(issue),
    .issue_wr(issue_wr), .issue_col(issue_col), .busy_o(burst_busy),
    .beat_o(burst_beat)
  );

  sdr_col_array #(.COL_W(COL_W), .DW(DW)) u_arr (
    .clk(clk), .en(issue), .we(issue_wr && !dm_in), .addr(issue_col),
    .wdata(wdata_in), .rdata(arr_q)
  );

  sdr_read_pipe #(.DW(DW), .MAX_CL(MAX_CL), .MASK_LAT(MASK_LAT)) u_rpipe (
    .clk(clk), .rst(rst), .act(act), .issue_rd(issue && !issue_wr),
    .arr_q(arr_q), .dm(dm_in), .cas3(mode_q.cas3), .dout(rdata_out),
    .dvalid(rd_valid_out)
  );
endmodule

// File: rtl/sdr_col_engine_chk.sv
module sdr_col_engine_chk #(
  parameter int DW     = 8,
  parameter int BEAT_W = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          cke_in,
  input logic [1:0]    cmd_in,
  input logic          dm_in,
  input logic          rd_valid_out,
  input logic [DW-1:0] rdata_out,
  input logic          act,
  input logic          busy,
  input logic          cas3,
  input logic          wr_single,
  input logic [BEAT_W:0] beat
);
  logic [2:0] since;
  always_ff @(posedge clk) begin
    if (rst) since <= '0;
    else if (since != 3'd7) since <= since + 3'd1;
  end

  assert_cas2_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (since >= 3'd3 && $past(act && cmd_in == 2'd1 && !cas3 && !dm_in && cke_in, 3)
     && $past(cke_in, 2)) |-> rd_valid_out);

  assert_single_write_R7: assert property (@(posedge clk) disable iff (rst)
    (act && cmd_in == 2'd2 && wr_single) |=> !busy);

  assert_hold_output_R8: assert property (@(posedge clk) disable iff (rst)
    (since >= 3'd2 && !$past(cke_in, 2)) |-> ($stable(rdata_out) && $stable(rd_valid_out)));

  assert_counter_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    !act |=> ($stable(beat) && $stable(busy)));

  assert_read_mask_R12: assert property (@(posedge clk) disable iff (rst)
    (since >= 3'd3 && $past(act && dm_in && cke_in, 3) && $past(cke_in, 2)) |-> !rd_valid_out);

  assert_idle_zero_R13: assert property (@(posedge clk) disable iff (rst)
    !rd_valid_out |-> (rdata_out == '0));
endmodule

bind sdr_col_engine sdr_col_engine_chk #(.DW(DW), .BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst(rst), .cke_in(cke_in), .cmd_in(cmd_in), .dm_in(dm_in),
  .rd_valid_out(rd_valid_out), .rdata_out(rdata_out), .act(act),
  .busy(burst_busy), .cas3(mode_q.cas3), .wr_single(mode_q.wr_single),
  .beat(burst_beat)
);

// File: tb/sim_sdr_col_engine.sv
module sim_sdr_col_engine;
  localparam int CLK_NS = 10;
  localparam int DW = 8;
  localparam int COL_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke_in = 1'b1;
  logic [1:0] cmd_in = 2'd0;
  logic [COL_W-1:0] col_in = '0;
  logic [9:0] mode_in = '0;
  logic [DW-1:0] wdata_in = '0;
  logic dm_in = 1'b0;
  logic [DW-1:0] rdata_out;
  logic rd_valid_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int e_edge = 0;
  bit done = 0;

  typedef struct {
    logic [DW-1:0] d;
    int            at;
    string         tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdr_col_engine u0 (
    .clk(clk), .rst(rst), .cke_in(cke_in), .cmd_in(cmd_in), .col_in(col_in),
    .mode_in(mode_in), .wdata_in(wdata_in), .dm_in(dm_in),
    .rdata_out(rdata_out), .rd_valid_out(rd_valid_out)
  );

  task automatic check(input bit ok, input string tag, input int actv, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h cycle=%0d", tag, actv, expv, cyc);
    end
  endtask

  task automatic drive(input logic [1:0] c, input int col, input logic [7:0] wd,
                       input logic m, input logic ck);
    @(negedge clk);
    cmd_in   = c;
    col_in   = col[COL_W-1:0];
    wdata_in = wd;
    dm_in    = m;
    cke_in   = ck;
    e_edge   = cyc + 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(2'd0, 0, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic load_mode(input int bl, input bit ilv, input bit cl3, input bit ws);
    @(negedge clk);
    cmd_in  = 2'd3;
    mode_in = '0;
    mode_in[1:0] = bl[1:0];
    mode_in[2]   = ilv;
    mode_in[4]   = cl3;
    mode_in[9]   = ws;
    dm_in   = 1'b0;
    cke_in  = 1'b1;
  endtask

  task automatic push(input logic [7:0] d, input int at, input string tag);
    exp_t it;
    it.d = d; it.at = at; it.tag = tag;
    q.push_back(it);
  endtask

  // scoreboard monitor: compares each driven read word against the queue
  always @(negedge clk) begin
    if (!rst) begin
      while (q.size() > 0 && q[0].at < cyc) begin
        check(1'b0, {q[0].tag, " missing word"}, 0, int'(q[0].d));
        void'(q.pop_front());
      end
      if (rd_valid_out) begin
        if (q.size() == 0 || q[0].at != cyc) begin
          check(1'b0, "R13 unexpected valid", int'(rdata_out), 0);
        end else begin
          check(rdata_out == q[0].d, q[0].tag, int'(rdata_out), int'(q[0].d));
          void'(q.pop_front());
        end
      end
    end
  end

  initial begin
    #(CLK_NS * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rd_valid_out == 1'b0, "R1 valid after reset", int'(rd_valid_out), 0);
    check(rdata_out == '0, "R1 data after reset", int'(rdata_out), 0);

    // R1 defaults: burst length 1, CAS 2
    drive(2'd2, 3, 8'h3C, 1'b0, 1'b1);
    drive(2'd0, 0, 8'h99, 1'b0, 1'b1);
    drive(2'd1, 3, 8'h00, 1'b0, 1'b1);
    push(8'h3C, e_edge + 2, "R1 default single read");
    idle(6);

    // R2 R4 R6: BL4 sequential write from col 5 -> 5,6,7,4
    load_mode(2, 0, 0, 0);
    drive(2'd2, 5, 8'h11, 1'b0, 1'b1);
    drive(2'd0, 0, 8'h22, 1'b0, 1'b1);
    drive(2'd0, 0, 8'h33, 1'b0, 1'b1);
    drive(2'd0, 0, 8'h44, 1'b0, 1'b1);
    drive(2'd1, 5, 8'h00, 1'b0, 1'b1);
    push(8'h11, e_edge + 2, "R3 cas2 beat0");
    push(8'h22, e_edge + 3, "R4 seq beat1");
    push(8'h33, e_edge + 4, "R4 seq beat2");
    push(8'h44, e_edge + 5, "R6 wrapped write beat");
    idle(8);

    // R5: interleaved read from col 5 -> 5,4,7,6
    load_mode(2, 1, 0, 0);
    drive(2'd1, 5, 8'h00, 1'b0, 1'b1);
    push(8'h11, e_edge + 2, "R5 ilv beat0");
    push(8'h44, e_edge + 3, "R5 ilv beat1");
    push(8'h33, e_edge + 4, "R5 ilv beat2");
    push(8'h22, e_edge + 5, "R5 ilv beat3");
    idle(8);

    // R3: CAS latency 3, col 4 sequential -> 4,5,6,7
    load_mode(2, 0, 1, 0);
    drive(2'd1, 4, 8'h00, 1'b0, 1'b1);
    push(8'h44, e_edge + 3, "R3 cas3 beat0");
    push(8'h11, e_edge + 4, "R3 cas3 beat1");
    push(8'h22, e_edge + 5, "R3 cas3 beat2");
    push(8'h33, e_edge + 6, "R3 cas3 beat3");
    idle(9);

    // R11: write mask on beat 1
    load_mode(2, 0, 0, 0);
    drive(2'd2, 28, 8'hA0, 1'b0, 1'b1);
    drive(2'd0, 0, 8'hA1, 1'b0, 1'b1);
    drive(2'd0, 0, 8'hA2, 1'b0, 1'b1);
    drive(2'd0, 0, 8'hA3, 1'b0, 1'b1);
    drive(2'd2, 28, 8'hB0, 1'b0, 1'b1);
    drive(2'd0, 0, 8'hFF, 1'b1, 1'b1);
    drive(2'd0, 0, 8'hB2, 1'b0, 1'b1);
    drive(2'd0, 0, 8'hB3, 1'b0, 1'b1);
    idle(3);
    drive(2'd1, 28, 8'h00, 1'b0, 1'b1);
    push(8'hB0, e_edge + 2, "R11 beat0");
    push(8'hA1, e_edge + 3, "R11 masked column kept");
    push(8'hB2, e_edge + 4, "R11 beat2");
    push(8'hB3, e_edge + 5, "R11 beat3");
    idle(8);

    // R12: read mask on edge E+1 blanks the word after E+3
    drive(2'd1, 28, 8'h00, 1'b0, 1'b1);
    push(8'hB0, e_edge + 2, "R12 unmasked beat0");
    push(8'hB2, e_edge + 4, "R12 beat2 after gap");
    push(8'hB3, e_edge + 5, "R12 beat3");
    drive(2'd0, 0, 8'h00, 1'b1, 1'b1);
    idle(8);

    // R7: write-single mode, reads still BL4
    load_mode(2, 0, 0, 1);
    drive(2'd2, 30, 8'h55, 1'b0, 1'b1);
    drive(2'd0, 0, 8'h66, 1'b0, 1'b1);
    drive(2'd0, 0, 8'h66, 1'b0, 1'b1);
    drive(2'd0, 0, 8'h66, 1'b0, 1'b1);
    drive(2'd1, 28, 8'h00, 1'b0, 1'b1);
    push(8'hB0, e_edge + 2, "R7 read beat0");
    push(8'hA1, e_edge + 3, "R7 read beat1");
    push(8'h55, e_edge + 4, "R7 single write stored");
    push(8'hB3, e_edge + 5, "R7 next column untouched");
    idle(8);

    // R9: suspended edge inside a write burst
    load_mode(2, 0, 0, 0);
    drive(2'd2, 8, 8'h80, 1'b0, 1'b1);
    drive(2'd0, 0, 8'h81, 1'b0, 1'b0);
    drive(2'd0, 0, 8'hEE, 1'b0, 1'b1);
    drive(2'd0, 0, 8'h82, 1'b0, 1'b1);
    drive(2'd0, 0, 8'h83, 1'b0, 1'b1);
    idle(2);
    drive(2'd1, 8, 8'h00, 1'b0, 1'b1);
    push(8'h80, e_edge + 2, "R9 beat0");
    push(8'h81, e_edge + 3, "R9 beat1");
    push(8'h82, e_edge + 4, "R9 beat2 after suspend");
    push(8'h83, e_edge + 5, "R9 beat3");
    idle(8);

    // R8: suspension during read output, ignored write
    drive(2'd1, 28, 8'h00, 1'b0, 1'b1);
    push(8'hB0, e_edge + 2, "R8 beat0");
    push(8'hA1, e_edge + 3, "R8 beat1");
    push(8'hA1, e_edge + 4, "R8 output held");
    push(8'h55, e_edge + 5, "R8 beat2 resumed");
    push(8'hB3, e_edge + 6, "R8 beat3");
    drive(2'd0, 0, 8'h00, 1'b0, 1'b1);
    drive(2'd0, 0, 8'h00, 1'b0, 1'b1);
    drive(2'd0, 0, 8'h00, 1'b0, 1'b0);
    drive(2'd2, 30, 8'h77, 1'b0, 1'b1);
    idle(8);
    drive(2'd1, 28, 8'h00, 1'b0, 1'b1);
    push(8'hB0, e_edge + 2, "R8 readback beat0");
    push(8'hA1, e_edge + 3, "R8 readback beat1");
    push(8'h55, e_edge + 4, "R8 ignored write absent");
    push(8'hB3, e_edge + 5, "R8 readback beat3");
    idle(8);

    // R10: BL8, new read interrupts a running one
    load_mode(3, 0, 0, 0);
    drive(2'd2, 40, 8'hC0, 1'b0, 1'b1);
    for (int i = 1; i < 8; i++) drive(2'd0, 0, 8'hC0 + 8'(i), 1'b0, 1'b1);
    drive(2'd1, 42, 8'h00, 1'b0, 1'b1);
    push(8'hC2, e_edge + 2, "R10 first burst beat0");
    push(8'hC3, e_edge + 3, "R10 first burst beat1");
    drive(2'd0, 0, 8'h00, 1'b0, 1'b1);
    drive(2'd1, 44, 8'h00, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++)
      push(8'hC0 + 8'((4 + i) % 8), e_edge + 2 + i, "R10 restarted burst");
    idle(14);

    // R2: back to burst length 1
    load_mode(0, 0, 0, 0);
    drive(2'd1, 41, 8'h00, 1'b0, 1'b1);
    push(8'hC1, e_edge + 2, "R2 reloaded BL1");
    idle(8);

    check(q.size() == 0, "R13 queue drained", q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule